// File: doc/BRIEF.md
# Sector Erase Window Accumulator

This block gathers sector-erase requests for a flash array into one batch. Each accepted request marks its sector in an eight-bit selection mask. After every write it opens, or reopens, an acceptance window that is measured in ticks of a 1 µs enable. When a full window passes with no new write, the block issues a single start pulse. That pulse launches one concurrent erase of every sector in the mask.

Any other command that arrives while the window is open cancels the batch. The mask is discarded and a one-cycle pulse tells the command logic to go back to read mode. Once the erase has been launched, the block ignores every request, write edge and command until the erase engine reports completion through `erase_done`. It then clears the mask and returns to idle.

All inputs are single-cycle control strobes sampled on the rising clock edge. None of them carries a data stream, so there is no valid/ready handshake and no back-pressure. A strobe the block does not accept is dropped.

Top module: `sector_erase_batcher`

## Requirements
- R1: An accepted request with `req_sector` = n sets bit n of `sector_mask` (bit 0 = sector 0) on the next clock. Bits set earlier remain set, so any combination of the eight sectors, up to all eight (8'hFF), can be gathered.
- R2: When WIN_TICKS ticks have been sampled in the window after the last restart with no restart, `erase_start` is high for exactly one cycle in the clock after the last such tick. `window_open` falls in that same cycle.
- R3: A request or a write edge while the window is open restarts the tick count from zero, so the window stays open for WIN_TICKS further ticks.
- R4: A request that arrives after the window has expired (during the erase) does not change `sector_mask`.
- R5: A command strobe (`other_cmd`) during the window clears `sector_mask`, closes the window, and gives a one-cycle `abort_read` pulse without any `erase_start`. It takes priority over a request in the same cycle.
- R6: While `erase_active` is high and `erase_done` is low, requests, write edges and commands have no effect: the mask stays the same and neither pulse occurs.
- R7: `erase_active` is 0 while the window is open. It is 1 from the cycle of `erase_start` until the cycle after `erase_done`. `window_open` and `erase_active` are never both high.
- R8: `erase_done` during the erase clears `sector_mask` and returns to idle on the next clock. `erase_done` outside an erase has no effect.
- R9: After reset `sector_mask` is 0 and all outputs are low.
- R10: In idle, `wr_edge` and `other_cmd` have no effect: no window opens and no `abort_read` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle 1 µs time-base enable |
| req_vld | input | 1 | Sector-erase request strobe |
| req_sector | input | 3 | Sector number of the request |
| wr_edge | input | 1 | Bus write-edge strobe |
| other_cmd | input | 1 | Strobe for any command other than sector erase |
| erase_done | input | 1 | Erase engine completion strobe |
| sector_mask | output | 8 | Selected sectors, bit n = sector n |
| window_open | output | 1 | Acceptance window running |
| erase_active | output | 1 | Status flag: erase launched and not yet done |
| erase_start | output | 1 | One-cycle pulse that launches the erase |
| abort_read | output | 1 | One-cycle pulse requesting return to read mode |

## Verification
The batch function is driven with several patterns. A lone request followed by an uninterrupted window pins the expiry to the exact tick. A second request and a bare write edge placed inside the window show that both restart the count rather than adding to it. A request ring over all eight sectors shows that bits accumulate instead of replacing one another. A command strobe inside the window, alone and in the same cycle as a request, separates the cancel path from the accept path. Requests, commands and stray completions sent during the erase and while idle show that those states hold their mask.

// File: rtl/seb_pkg.sv
package seb_pkg;
  typedef enum logic [1:0] {
    SEB_IDLE   = 2'd0,
    SEB_WINDOW = 2'd1,
    SEB_ERASE  = 2'd2
  } seb_state_e;
endpackage

// File: rtl/seb_window_timer.sv
module seb_window_timer #(
  parameter int WIN_TICKS = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(WIN_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_TICKS - 1);

  logic [CW-1:0] cnt;

  assign expire = run && !restart && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !run) begin
      cnt <= '0;
    end else if (tick && !expire) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/seb_mask_bank.sv
module seb_mask_bank #(
  parameter int SECTORS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       set_en,
  input  logic [$clog2(SECTORS)-1:0] set_sel,
  input  logic                       clear,
  output logic [SECTORS-1:0]         mask
);
  localparam int SW = $clog2(SECTORS);

  for (genvar i = 0; i < SECTORS; i++) begin : g_bit
    logic hit;
    assign hit = set_en && (set_sel == SW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask[i] <= 1'b0;
      end else if (clear) begin
        mask[i] <= 1'b0;
      end else if (hit) begin
        mask[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/seb_seq_ctrl.sv
module seb_seq_ctrl
  import seb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_vld,
  input  logic wr_edge,
  input  logic other_cmd,
  input  logic erase_done,
  input  logic expire,
  output logic accept,
  output logic clear,
  output logic restart,
  output logic run,
  output logic window_open,
  output logic erase_active,
  output logic start_pulse,
  output logic abort_pulse
);
  seb_state_e state, state_nx;
  logic in_win, cancel, fire, finish;

  assign in_win  = (state == SEB_WINDOW);
  assign cancel  = in_win && other_cmd;
  assign accept  = req_vld && ((state == SEB_IDLE) || (in_win && !other_cmd));
  assign restart = accept || (in_win && wr_edge);
  assign run     = in_win;
  assign fire    = in_win && !other_cmd && expire;
  assign finish  = (state == SEB_ERASE) && erase_done;
  assign clear   = cancel || finish;

  always_comb begin
    state_nx = state;
    unique case (state)
      SEB_IDLE:   if (accept) state_nx = SEB_WINDOW;
      SEB_WINDOW: begin
        if (cancel)    state_nx = SEB_IDLE;
        else if (fire) state_nx = SEB_ERASE;
      end
      SEB_ERASE:  if (finish) state_nx = SEB_IDLE;
      default:    state_nx = SEB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SEB_IDLE;
      start_pulse <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      state       <= state_nx;
      start_pulse <= fire;
      abort_pulse <= cancel;
    end
  end

  assign window_open  = in_win;
  assign erase_active = (state == SEB_ERASE);
endmodule

// File: rtl/sector_erase_batcher.sv
module sector_erase_batcher #(
  parameter int SECTORS   = 8,
  parameter int WIN_TICKS = 80,
  localparam int SW       = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_us,
  input  logic               req_vld,
  input  logic [SW-1:0]      req_sector,
  input  logic               wr_edge,
  input  logic               other_cmd,
  input  logic               erase_done,
  output logic [SECTORS-1:0] sector_mask,
  output logic               window_open,
  output logic               erase_active,
  output logic               erase_start,
  output logic               abort_read
);
  logic accept, clear, restart, run, expire;

  seb_seq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_vld      (req_vld),
    .wr_edge      (wr_edge),
    .other_cmd    (other_cmd),
    .erase_done   (erase_done),
    .expire       (expire),
    .accept       (accept),
    .clear        (clear),
    .restart      (restart),
    .run          (run),
    .window_open  (window_open),
    .erase_active (erase_active),
    .start_pulse  (erase_start),
    .abort_pulse  (abort_read)
  );

  seb_window_timer #(.WIN_TICKS(WIN_TICKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (restart),
    .tick    (tick_us),
    .expire  (expire)
  );

  seb_mask_bank #(.SECTORS(SECTORS)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (accept),
    .set_sel (req_sector),
    .clear   (clear),
    .mask    (sector_mask)
  );
endmodule

// File: rtl/seb_checker.sv
module seb_checker #(
  parameter int SECTORS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               erase_done,
  input logic [SECTORS-1:0] sector_mask,
  input logic               window_open,
  input logic               erase_active,
  input logic               erase_start,
  input logic               abort_read
);
  // R1
  window_mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    window_open |-> (sector_mask != '0));

  // R2
  start_follows_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (erase_active && $past(window_open)));

  // R5
  abort_clears_batch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_read |-> (sector_mask == '0 && !window_open && !erase_start));

  // R6
  erase_holds_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_active && !erase_done) |=> ($stable(sector_mask) && !abort_read && !erase_start));

  // R7
  status_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({window_open, erase_active}));

  // R8
  done_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_active && erase_done) |=> (sector_mask == '0 && !erase_active));

  // R9
  idle_mask_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_open && !erase_active) |-> (sector_mask == '0));
endmodule

bind sector_erase_batcher seb_checker #(.SECTORS(SECTORS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .erase_done   (erase_done),
  .sector_mask  (sector_mask),
  .window_open  (window_open),
  .erase_active (erase_active),
  .erase_start  (erase_start),
  .abort_read   (abort_read)
);

// File: tb/sector_erase_batcher_tb.sv
`timescale 1ns/1ps
module sector_erase_batcher_tb;
  localparam int W = 80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_us = 0, req_vld = 0, wr_edge = 0, other_cmd = 0, erase_done = 0;
  logic [2:0] req_sector = '0;
  logic [7:0] sector_mask;
  logic window_open, erase_active, erase_start, abort_read;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sector_erase_batcher u_dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .req_vld(req_vld),
    .req_sector(req_sector), .wr_edge(wr_edge), .other_cmd(other_cmd),
    .erase_done(erase_done), .sector_mask(sector_mask), .window_open(window_open),
    .erase_active(erase_active), .erase_start(erase_start), .abort_read(abort_read)
  );

  // Behavioural reference: 0 idle, 1 window, 2 erasing
  int m_mode = 0, m_ticks = 0;
  logic [7:0] m_mask = '0;
  bit m_start = 0, m_abort = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_ticks = 0; m_mask = '0; m_start = 0; m_abort = 0;
    end else begin
      m_start = 0; m_abort = 0;
      if (m_mode == 0) begin
        if (req_vld) begin m_mask = 8'(1 << req_sector); m_ticks = 0; m_mode = 1; end
      end else if (m_mode == 1) begin
        if (other_cmd) begin m_mask = '0; m_abort = 1; m_mode = 0; end
        else if (req_vld) begin m_mask = m_mask | 8'(1 << req_sector); m_ticks = 0; end
        else if (wr_edge) m_ticks = 0;
        else if (tick_us) begin
          m_ticks++;
          if (m_ticks == W) begin m_mode = 2; m_start = 1; end
        end
      end else begin
        if (erase_done) begin m_mask = '0; m_mode = 0; end
      end
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R1 mask vs model", sector_mask, m_mask);
      check("R3 window_open vs model", 8'(window_open), 8'(m_mode == 1));
      check("R2 erase_start vs model", 8'(erase_start), 8'(m_start));
      check("R5 abort_read vs model", 8'(abort_read), 8'(m_abort));
      check("R7 erase_active vs model", 8'(erase_active), 8'(m_mode == 2));
    end
  end

  task automatic drive(bit rq, int sc, bit we, bit oc, bit dn, bit tk);
    req_vld = rq; req_sector = 3'(sc); wr_edge = we; other_cmd = oc;
    erase_done = dn; tick_us = tk;
    @(posedge clk); #1;
    req_vld = 0; wr_edge = 0; other_cmd = 0; erase_done = 0; tick_us = 0;
  endtask

  task automatic run_ticks(int n);
    repeat (n) drive(0, 0, 0, 0, 0, 1);
  endtask

  task automatic summary();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9 reset state
    check("R9 mask after reset", sector_mask, 8'h00);
    check("R9 outputs after reset", {4'b0, window_open, erase_active, erase_start, abort_read}, 8'h00);

    // R10 idle ignores write edge and command
    drive(0, 0, 1, 1, 0, 1);
    check("R10 idle command", {5'b0, window_open, abort_read, erase_active}, 8'h00);

    // R1/R3 accumulate and restart
    drive(1, 2, 0, 0, 0, 0);
    check("R1 first sector", sector_mask, 8'h04);
    run_ticks(30);
    drive(1, 7, 0, 0, 0, 0);
    check("R1 second sector", sector_mask, 8'h84);
    run_ticks(40);
    drive(0, 0, 1, 0, 0, 0);
    run_ticks(W - 1);
    check("R3 window still open after restart", 8'(window_open), 8'h01);
    run_ticks(1);
    check("R2 erase_start on last tick", 8'(erase_start), 8'h01);
    check("R7 flag set at start", {6'b0, window_open, erase_active}, 8'h01);

    // R4/R6 erasing ignores inputs
    drive(1, 0, 0, 0, 0, 1);
    check("R2 start is one cycle", 8'(erase_start), 8'h00);
    check("R4 late request not added", sector_mask, 8'h84);
    drive(0, 0, 1, 1, 0, 1);
    check("R6 command during erase", {abort_read, erase_active, sector_mask[5:0]}, 8'h44);
    run_ticks(100);
    check("R6 still erasing", 8'(erase_active), 8'h01);

    // R8 done
    drive(0, 0, 0, 0, 1, 0);
    check("R8 mask cleared by done", sector_mask, 8'h00);
    check("R8 idle after done", {6'b0, window_open, erase_active}, 8'h00);
    drive(0, 0, 0, 0, 1, 0);
    check("R8 stray done", {6'b0, window_open, erase_active}, 8'h00);

    // R5 cancel
    drive(1, 3, 0, 0, 0, 0);
    drive(1, 5, 0, 0, 0, 0);
    check("R1 two sectors", sector_mask, 8'h28);
    run_ticks(10);
    drive(0, 0, 0, 1, 0, 1);
    check("R5 abort pulse", 8'(abort_read), 8'h01);
    check("R5 mask cleared", sector_mask, 8'h00);
    check("R5 no start", {6'b0, window_open, erase_start}, 8'h00);
    drive(0, 0, 0, 0, 0, 1);
    check("R5 abort one cycle", 8'(abort_read), 8'h00);
    drive(1, 1, 0, 0, 0, 0);
    drive(1, 6, 0, 1, 0, 0);
    check("R5 command beats request", sector_mask, 8'h00);
    check("R5 abort with request", 8'(abort_read), 8'h01);

    // R1 all eight sectors
    for (int s = 0; s < 8; s++) drive(1, s, 0, 0, 0, 0);
    check("R1 all sectors", sector_mask, 8'hFF);
    run_ticks(W - 1);
    check("R2 open before last tick", {6'b0, window_open, erase_start}, 8'h02);
    run_ticks(1);
    check("R2 start after full window", {6'b0, erase_active, erase_start}, 8'h03);
    drive(0, 0, 0, 0, 1, 0);
    check("R8 full batch done", sector_mask, 8'h00);
    repeat (3) drive(0, 0, 0, 0, 0, 0);
    summary();
  end
endmodule